// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block collects thirteen hardware interrupt lines plus one internal software request and presents the single most urgent one to a processor core. Priority 0 is a non-maskable, edge-captured request. Priorities 1 to 13 are maskable. Among them, the three sources at priorities 7, 8 and 9 are edge-captured, the software request (priority 13) is a flag, and the others follow their input level.

A small register set controls the block. It holds a 16-bit mask, a base/control word whose upper six bits place the vector table, and a configuration word with a global disable bit. When a request survives masking, the controller raises a request line with the winning priority number and a 20-bit vector. Writing the base/control word raises the software request, and reading that word clears it. The core acknowledges a serviced source by priority number, which retires a captured edge.

Top module: `prio_vec_intc`

## Requirements
- R1: After reset, irq_req is 0, the mask reads 16'hFFFF (every source masked), the configuration reads 16'h0010 (disabled), and the base/control word reads 0.
- R2: A rising edge on irq_src[0] sets a pending non-maskable request. It is delivered as priority 0 whatever the mask bits and the disable bit are. It stays pending until an acknowledge with ack_prio = 0, and a line held high does not raise it again.
- R3: Maskable priority p (1 to 13) is blocked while bit p of the mask register is 1, and can be delivered while that bit is 0.
- R4: Sources 7, 8 and 9 capture a rising edge. The capture stays pending after the line falls, is unaffected by acknowledges naming other priorities, and clears on an acknowledge naming its own priority.
- R5: Sources 1 to 6 and 10 to 12 are level sources. Their request follows the input one clock later and disappears one clock after the input falls.
- R6: While bit 4 of the configuration register is 1, no maskable priority is delivered.
- R7: When several requests are deliverable, irq_prio is the lowest priority number among them.
- R8: irq_vector bits 19:16 are 0, bits 15:10 equal base/control bits 15:10, and bits 9:0 equal 0x1E0 − 0x20·irq_prio.
- R9: Any write to the base/control register sets the software request (priority 13). A read of that register clears it. If a write and a read happen in the same cycle, the request is set.
- R10: reg_rdata returns the register chosen by reg_sel (0 mask, 1 base/control, 2 configuration, 3 reads zero). Register writes take effect at the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_src | input | 13 | Hardware request lines, bit index = priority |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effect on base/control only) |
| reg_sel | input | 2 | Register select |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data of the selected register |
| ack_valid | input | 1 | Acknowledge strobe from the core |
| ack_prio | input | 4 | Priority being acknowledged |
| irq_req | output | 1 | Request to the core |
| irq_prio | output | 4 | Winning priority |
| irq_vector | output | 20 | Service routine address |

## Verification
The bench builds the block with its default parameters: fourteen priorities, a 16-bit data path, a 20-bit vector and edge capture on priorities 0, 7, 8 and 9. These defaults cover the whole vector table, from 0x1E0 down to 0x40, and let every edge/level mix and every mask bit be driven. Random toggling of the request lines, together with register traffic and acknowledges, exercises ties between several pending sources. It also reaches the write-and-read collision on the software flag.

// File: rtl/prio_vec_intc.sv
module prio_vec_intc #(
  parameter int NSRC     = 14,
  parameter int DW       = 16,
  parameter int VW       = 20,
  parameter int BASE_LSB = 10,
  parameter int OW       = 10,
  parameter int DIS_BIT  = 4,
  parameter logic [NSRC-1:0] EDGE_MAP = 14'b00_0011_1000_0001,
  parameter logic [OW-1:0]   TOP_OFS  = 10'h1E0,
  parameter logic [OW-1:0]   OFS_STEP = 10'h020
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-2:0]   irq_src,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [1:0]        reg_sel,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  input  logic              ack_valid,
  input  logic [$clog2(NSRC)-1:0] ack_prio,
  output logic              irq_req,
  output logic [$clog2(NSRC)-1:0] irq_prio,
  output logic [VW-1:0]     irq_vector
);
  localparam int PW  = $clog2(NSRC);
  localparam int NHW = NSRC - 1;
  localparam int SWI = NSRC - 1;
  localparam int BW  = DW - BASE_LSB;
  localparam int ZW  = VW - BW - OW;

  localparam logic [1:0] SEL_MASK = 2'd0;
  localparam logic [1:0] SEL_BASE = 2'd1;
  localparam logic [1:0] SEL_CFG  = 2'd2;

  logic [NHW-1:0]  src_q, lvl_q, edge_pend;
  logic            swi_pend;
  logic [DW-1:0]   mask_q, base_q, cfg_q;
  logic [NHW-1:0]  rise;
  logic [NSRC-1:0] raw, live;
  logic [PW-1:0]   win;
  logic            any;

  wire base_wr = reg_wr && reg_sel == SEL_BASE;
  wire base_rd = reg_rd && reg_sel == SEL_BASE;

  assign rise = irq_src & ~src_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_q     <= '0;
      lvl_q     <= '0;
      edge_pend <= '0;
      swi_pend  <= 1'b0;
      mask_q    <= '1;
      base_q    <= '0;
      cfg_q     <= DW'(1) << DIS_BIT;
    end else begin
      src_q <= irq_src;
      lvl_q <= irq_src;
      for (int i = 0; i < NHW; i++) begin
        if (EDGE_MAP[i])
          edge_pend[i] <= (edge_pend[i] & ~(ack_valid && ack_prio == PW'(i))) | rise[i];
        else
          edge_pend[i] <= 1'b0;
      end
      if (base_wr)      swi_pend <= 1'b1;
      else if (base_rd) swi_pend <= 1'b0;
      if (reg_wr && reg_sel == SEL_MASK) mask_q <= reg_wdata;
      if (base_wr)                       base_q <= reg_wdata;
      if (reg_wr && reg_sel == SEL_CFG)  cfg_q  <= reg_wdata;
    end
  end

  genvar g;
  generate
    for (g = 0; g < NHW; g++) begin : g_raw
      if (EDGE_MAP[g]) begin : g_edge
        assign raw[g] = edge_pend[g];
      end else begin : g_lvl
        assign raw[g] = lvl_q[g];
      end
    end
  endgenerate
  assign raw[SWI] = swi_pend;

  assign live[0]      = raw[0];
  assign live[NSRC-1:1] = raw[NSRC-1:1] & ~mask_q[NSRC-1:1] & {(NSRC-1){~cfg_q[DIS_BIT]}};

  always_comb begin
    win = '0;
    any = 1'b0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (live[i]) begin
        win = PW'(i);
        any = 1'b1;
      end
    end
  end

  assign irq_req    = any;
  assign irq_prio   = win;
  assign irq_vector = {{ZW{1'b0}}, base_q[DW-1:BASE_LSB], TOP_OFS - OFS_STEP * OW'(win)};

  always_comb begin
    case (reg_sel)
      SEL_MASK: reg_rdata = mask_q;
      SEL_BASE: reg_rdata = base_q;
      SEL_CFG:  reg_rdata = cfg_q;
      default:  reg_rdata = '0;
    endcase
  end
endmodule

module prio_vec_intc_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_wr,
  input logic        reg_rd,
  input logic [1:0]  reg_sel,
  input logic        ack_valid,
  input logic [3:0]  ack_prio,
  input logic        irq_req,
  input logic [3:0]  irq_prio,
  input logic        nmi_pend,
  input logic        swi_pend,
  input logic [15:0] mask_q,
  input logic [15:0] cfg_q
);
  a_r9_swi_set: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && reg_sel == 2'd1 |=> swi_pend);
  a_r9_swi_clear: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd && reg_sel == 2'd1 && !reg_wr |=> !swi_pend);
  a_r2_nmi_holds: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_pend && !(ack_valid && ack_prio == 4'd0) |=> nmi_pend);
  a_r2_nmi_first: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_pend |-> irq_req && irq_prio == 4'd0);
  a_r3_mask_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req && irq_prio != 4'd0 |-> !mask_q[irq_prio]);
  a_r6_global_off: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req && irq_prio != 4'd0 |-> !cfg_q[4]);
endmodule

bind prio_vec_intc prio_vec_intc_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_sel(reg_sel),
  .ack_valid(ack_valid), .ack_prio(ack_prio), .irq_req(irq_req), .irq_prio(irq_prio),
  .nmi_pend(edge_pend[0]), .swi_pend(swi_pend), .mask_q(mask_q), .cfg_q(cfg_q)
);

// File: tb/tb_prio_vec_intc.sv
module tb_prio_vec_intc;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [12:0] irq_src = 0;
  logic        reg_wr = 0, reg_rd = 0;
  logic [1:0]  reg_sel = 0;
  logic [15:0] reg_wdata = 0;
  logic [15:0] reg_rdata;
  logic        ack_valid = 0;
  logic [3:0]  ack_prio = 0;
  logic        irq_req;
  logic [3:0]  irq_prio;
  logic [19:0] irq_vector;

  int checks = 0, fails = 0;
  bit done = 0;

  prio_vec_intc dut (.*);

  always #2 clk = ~clk;

  logic [12:0] m_prev, m_lvl, m_ep;
  logic        m_swi;
  logic [15:0] m_mask, m_base, m_cfg;
  localparam logic [12:0] EDGES = 13'h0381;

  task automatic m_reset();
    m_prev = 0; m_lvl = 0; m_ep = 0; m_swi = 0;
    m_mask = 16'hFFFF; m_base = 0; m_cfg = 16'h0010;
  endtask

  task automatic m_update();
    logic [12:0] rise;
    if (!rst_n) begin m_reset(); return; end
    rise = irq_src & ~m_prev;
    for (int i = 0; i < 13; i++)
      if (EDGES[i]) begin
        if (ack_valid && ack_prio == 4'(i)) m_ep[i] = 1'b0;
        if (rise[i]) m_ep[i] = 1'b1;
      end
    m_prev = irq_src;
    m_lvl  = irq_src;
    if (reg_wr && reg_sel == 1) m_swi = 1;
    else if (reg_rd && reg_sel == 1) m_swi = 0;
    if (reg_wr) case (reg_sel)
      2'd0: m_mask = reg_wdata;
      2'd1: m_base = reg_wdata;
      2'd2: m_cfg  = reg_wdata;
      default: ;
    endcase
  endtask

  function automatic int exp_prio();
    for (int p = 0; p < 14; p++) begin
      bit r;
      if (p == 13) r = m_swi;
      else r = EDGES[p] ? m_ep[p] : m_lvl[p];
      if (p == 0 && r) return 0;
      if (p != 0 && r && !m_mask[p] && !m_cfg[4]) return p;
    end
    return -1;
  endfunction

  function automatic logic [15:0] exp_rdata();
    case (reg_sel)
      2'd0: return m_mask;
      2'd1: return m_base;
      2'd2: return m_cfg;
      default: return 16'h0;
    endcase
  endfunction

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic compare(string tag);
    int p = exp_prio();
    chk(irq_req == (p >= 0), {tag, " R7 req"}, 32'(irq_req), 32'(p >= 0));
    if (p >= 0) begin
      chk(irq_prio == 4'(p), {tag, " R7 prio"}, 32'(irq_prio), 32'(p));
      chk(irq_vector == {4'h0, m_base[15:10], 10'(480 - 32 * p)}, {tag, " R8 vector"},
          32'(irq_vector), 32'({4'h0, m_base[15:10], 10'(480 - 32 * p)}));
    end
    chk(reg_rdata == exp_rdata(), {tag, " R10 rdata"}, 32'(reg_rdata), 32'(exp_rdata()));
  endtask

  task automatic cycle(string tag);
    @(posedge clk);
    m_update();
    @(negedge clk);
    compare(tag);
  endtask

  task automatic idle();
    reg_wr = 0; reg_rd = 0; ack_valid = 0;
  endtask

  task automatic wr(logic [1:0] s, logic [15:0] d, string tag);
    reg_sel = s; reg_wdata = d; reg_wr = 1; cycle(tag); idle();
  endtask

  initial begin
    #400000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2417));
    m_reset();
    repeat (3) cycle("R1");
    rst_n = 1;
    reg_sel = 0; cycle("R1");
    chk(reg_rdata == 16'hFFFF && !irq_req, "R1 mask reset", 32'(reg_rdata), 32'hFFFF);
    reg_sel = 2; cycle("R1");
    chk(reg_rdata == 16'h0010, "R1 cfg reset", 32'(reg_rdata), 32'h0010);

    irq_src[0] = 1; cycle("R2");
    chk(irq_req && irq_prio == 0 && irq_vector == 20'h001E0, "R2 nmi despite mask/disable",
        32'(irq_vector), 32'h1E0);
    ack_valid = 1; ack_prio = 0; cycle("R2"); idle();
    cycle("R2");
    chk(!irq_req, "R2 held line no retrigger", 32'(irq_req), 0);
    irq_src[0] = 0;

    wr(2, 16'h0010, "R6"); wr(0, 16'h0000, "R6");
    irq_src[1] = 1; cycle("R6");
    chk(!irq_req, "R6 disabled", 32'(irq_req), 0);
    wr(2, 16'h0000, "R6");
    chk(irq_req && irq_prio == 1, "R6 enabled", 32'(irq_prio), 1);
    wr(0, 16'h0002, "R3");
    chk(!irq_req, "R3 mask bit1", 32'(irq_req), 0);
    wr(0, 16'h0000, "R3");
    irq_src[1] = 0; cycle("R5");
    chk(!irq_req, "R5 level drop", 32'(irq_req), 0);

    irq_src[7] = 1; cycle("R4"); irq_src[7] = 0; cycle("R4");
    chk(irq_req && irq_prio == 7, "R4 edge latched", 32'(irq_prio), 7);
    ack_valid = 1; ack_prio = 8; cycle("R4");
    chk(irq_req && irq_prio == 7, "R4 other ack", 32'(irq_prio), 7);
    ack_prio = 7; cycle("R4"); idle();
    chk(!irq_req, "R4 own ack", 32'(irq_req), 0);

    irq_src[2] = 1; irq_src[12] = 1; cycle("R5");
    chk(irq_prio == 2, "R7 lowest wins", 32'(irq_prio), 2);
    irq_src[2] = 0; irq_src[12] = 0; cycle("R5");

    reg_sel = 1; reg_wdata = 16'hFC00; reg_wr = 1; reg_rd = 1; cycle("R9"); idle();
    chk(irq_req && irq_prio == 13 && irq_vector == 20'h0FC40, "R9 write beats read R8",
        32'(irq_vector), 32'h0FC40);
    reg_rd = 1; cycle("R9"); idle();
    chk(!irq_req, "R9 read clears", 32'(irq_req), 0);

    for (int n = 0; n < 6000; n++) begin
      for (int b = 0; b < 13; b++) if ($urandom_range(0, 7) == 0) irq_src[b] = ~irq_src[b];
      reg_sel = 2'($urandom_range(0, 3));
      reg_wr = ($urandom_range(0, 9) == 0);
      reg_rd = ($urandom_range(0, 5) == 0);
      reg_wdata = 16'($urandom());
      if (reg_sel == 2 && $urandom_range(0, 3) != 0) reg_wdata[4] = 0;
      if (irq_req && $urandom_range(0, 1) == 0) begin
        ack_valid = 1; ack_prio = irq_prio;
      end else begin
        ack_valid = ($urandom_range(0, 9) == 0); ack_prio = 4'($urandom_range(0, 13));
      end
      cycle("R3 R4 R5 R6 R9");
    end
    idle();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule